// File: doc/BRIEF.md
# HDLC Serial Receive Deframer

This block turns a synchronous serial HDLC bit stream into bytes for a backend. It runs on the line clock and takes one bit per rising edge. It first searches the stream for a flag. It then strips the zero bits that the transmitter inserted, groups the remaining bits into bytes, and checks the frame check sequence (FCS). It also watches for abort runs. The FCS bytes at the end of a frame are held back and never presented as data.

The backend sees each byte through three signals:
- `ready`, which marks that a byte is waiting.
- A read strobe, which the backend drives to take the byte.
- A `frameValid` level, which covers the frame.

The end of a frame is marked by a one-cycle `frameEnd` pulse while `frameValid` is still high. At that moment `frameErr` reports whether the frame failed. A frame fails on:
- a bad FCS,
- data that is not a whole number of bytes,
- an abort,
- a byte the backend did not read in time.

Buffering, address filtering and clock recovery are left to the logic around the block.

Top module: `hdlcRxDeframer`

## Requirements
- R1: While `rstN` is low, `ready`, `frameValid`, `frameErr` and `frameEnd` are all low.
- R2: Bits are received LSB first. A frame lies between two flags (bit pattern 0x7E). Only its payload bytes are presented on `rxData`, in order, one per `ready`. The trailing FCS bytes are never presented.
- R3: A 0 bit that follows five consecutive 1 bits inside a frame is discarded. A payload containing runs of five or more 1s is delivered unchanged.
- R4: A frame whose CRC-16 FCS is correct ends with a `frameEnd` pulse and `frameErr` low. The FCS uses the reflected polynomial 0x8408 with start value 0xFFFF. It is sent complemented, low byte first. A correct frame leaves the residue 0xF0B8.
- R5: A frame whose FCS is wrong ends with `frameErr` high during `frameEnd`.
- R6: A frame whose bit count between the flags is not a multiple of eight ends with `frameErr` high during `frameEnd`.
- R7: Seven consecutive 1 bits abort the frame. If `frameValid` is high, the frame ends with `frameErr` high. If not, no `frameEnd` is produced.
- R8: Two flags back to back, or a frame with no more bytes than the FCS, never raise `frameValid`.
- R9: After `ready` rises, a read strobe sampled on any of the next 7 clock edges takes the byte without error. If no read is sampled by the 7th edge, `ready` falls and `frameErr` rises at once. `frameErr` then stays high while `frameValid` is high.
- R10: `frameEnd` lasts one cycle with `frameValid` high. On the next cycle `frameValid` and `frameErr` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; one serial bit per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Serial receive data |
| rdStb | input | 1 | Backend read strobe, sampled on the rising edge |
| rxData | output | 8 | Byte offered to the backend |
| ready | output | 1 | A byte is waiting to be read |
| frameValid | output | 1 | A frame with at least one delivered byte is in progress |
| frameErr | output | 1 | Error of the current frame |
| frameEnd | output | 1 | One-cycle end-of-frame marker |

## Verification
The hardest case to reach is the missed read window. The error must appear partway through a frame, while data is still arriving. It must also persist through the end of a frame whose FCS is otherwise correct. The bench reaches this with a backend model whose read delay is a variable. At a delay of 6 cycles it reads on the last legal edge, and the frame must end clean. At a delay of 7 cycles it never reads. The error must then appear before `frameEnd` and no byte may be taken.

Misalignment is produced by appending one extra data bit before the closing flag. That bit shifts the flag's tail off the byte boundary without completing a spurious byte.

// File: rtl/hdlcRxPkg.sv
`timescale 1ns/1ps
package hdlcRxPkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_OPEN = 1'b1
  } rxStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic dataEn;   // shift the current line bit as payload
    logic restart;  // flag seen: start a new frame
  } dpCtlT;

  // line symbol classification
  typedef struct packed {
    logic flag;
    logic abort;
    logic dataBit;
  } symT;

  // datapath status toward control
  typedef struct packed {
    logic byteOut;  // a byte leaves the FCS hold queue this cycle
    logic aligned;  // bit position matches a clean closing flag
    logic crcGood;  // checker holds the good residue
  } dpStatT;

endpackage

// File: rtl/hdlcRxLineSym.sv
`timescale 1ns/1ps
module hdlcRxLineSym
  import hdlcRxPkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxBit,
  output symT  sym
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int ONES_W    = $clog2(ABORT_RUN + 1);

  logic [ONES_W-1:0] onesCnt;

  always_comb begin
    sym.flag    = !rxBit && (onesCnt == ONES_W'(FLAG_RUN));
    sym.abort   = rxBit && (onesCnt == ONES_W'(FLAG_RUN));
    sym.dataBit = rxBit ? (onesCnt < ONES_W'(STUFF_RUN))
                        : ((onesCnt != ONES_W'(STUFF_RUN)) && (onesCnt != ONES_W'(FLAG_RUN)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesCnt <= ONES_W'(ABORT_RUN);
    end else if (rxBit) begin
      if (onesCnt != ONES_W'(ABORT_RUN)) onesCnt <= onesCnt + 1'b1;
    end else begin
      onesCnt <= '0;
    end
  end
endmodule

// File: rtl/hdlcRxDatapath.sv
`timescale 1ns/1ps
module hdlcRxDatapath
  import hdlcRxPkg::*;
#(
  parameter int FCS_BITS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  dpCtlT      ctl,
  output dpStatT     stat,
  output logic [7:0] evictByte
);
  localparam int HOLD  = FCS_BITS / 8;
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [FCS_BITS-1:0] POLY =
    (FCS_BITS == 32) ? FCS_BITS'(32'hEDB8_8320) : FCS_BITS'(32'h0000_8408);
  localparam logic [FCS_BITS-1:0] RESIDUE =
    (FCS_BITS == 32) ? FCS_BITS'(32'hDEBB_20E3) : FCS_BITS'(32'h0000_F0B8);

  logic [7:0]          shiftReg;
  logic [2:0]          bitCnt;
  logic [CNT_W-1:0]    heldCnt;
  logic [FCS_BITS-1:0] crcReg;
  logic [7:0]          holdQ [HOLD];
  logic [7:0]          newByte;
  logic                byteDone;

  function automatic logic [FCS_BITS-1:0] crcStep(input logic [FCS_BITS-1:0] c,
                                                  input logic [7:0] d);
    logic [FCS_BITS-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    newByte       = {rxBit, shiftReg[7:1]};
    byteDone      = ctl.dataEn && (bitCnt == 3'd7);
    stat.byteOut  = byteDone && (heldCnt == CNT_W'(HOLD));
    stat.aligned  = (bitCnt == 3'd6);
    stat.crcGood  = (crcReg == RESIDUE);
    evictByte     = holdQ[HOLD-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      heldCnt  <= '0;
      crcReg   <= '1;
    end else if (ctl.restart) begin
      bitCnt   <= '0;
      heldCnt  <= '0;
      crcReg   <= '1;
    end else if (ctl.dataEn) begin
      shiftReg <= newByte;
      bitCnt   <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        crcReg <= crcStep(crcReg, newByte);
        if (heldCnt != CNT_W'(HOLD)) heldCnt <= heldCnt + 1'b1;
      end
    end
  end

  // FCS hold queue: newest at index 0, oldest leaves from the far end
  always_ff @(posedge clk) begin
    if (!rstN)         holdQ[0] <= '0;
    else if (byteDone) holdQ[0] <= newByte;
  end

  for (genvar g = 1; g < HOLD; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN)         holdQ[g] <= '0;
      else if (byteDone) holdQ[g] <= holdQ[g-1];
    end
  end
endmodule

// File: rtl/hdlcRxControl.sv
`timescale 1ns/1ps
module hdlcRxControl
  import hdlcRxPkg::*;
#(
  parameter int READ_WINDOW = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  symT        sym,
  input  dpStatT     stat,
  input  logic [7:0] evictByte,
  input  logic       rdStb,
  output dpCtlT      ctl,
  output logic [7:0] rxData,
  output logic       ready,
  output logic       frameValid,
  output logic       frameErr,
  output logic       frameEnd
);
  localparam int AGE_W = $clog2(READ_WINDOW);

  rxStateT           state;
  logic [AGE_W-1:0]  age;
  logic              closeNow;
  logic              errNow;

  always_comb begin
    ctl.dataEn  = (state == ST_OPEN) && sym.dataBit;
    ctl.restart = sym.flag;
    closeNow    = frameValid && !frameEnd && (sym.flag || sym.abort);
    errNow      = sym.abort || !stat.aligned || !stat.crcGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_HUNT;
    end else if (sym.flag) begin
      state <= ST_OPEN;
    end else if (sym.abort) begin
      state <= ST_HUNT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      ready      <= 1'b0;
      age        <= '0;
      frameValid <= 1'b0;
      frameErr   <= 1'b0;
      frameEnd   <= 1'b0;
    end else begin
      if (frameEnd) begin
        frameEnd   <= 1'b0;
        frameValid <= 1'b0;
        frameErr   <= 1'b0;
      end
      if (closeNow) begin
        frameEnd <= 1'b1;
        frameErr <= frameErr | errNow;
        ready    <= 1'b0;
      end else if (stat.byteOut) begin
        rxData     <= evictByte;
        ready      <= 1'b1;
        age        <= '0;
        frameValid <= 1'b1;
      end else if (ready) begin
        if (rdStb) begin
          ready <= 1'b0;
        end else if (age == AGE_W'(READ_WINDOW - 1)) begin
          ready    <= 1'b0;
          frameErr <= 1'b1;
        end else begin
          age <= age + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlcRxDeframer.sv
`timescale 1ns/1ps
module hdlcRxDeframer
  import hdlcRxPkg::*;
#(
  parameter int FCS_BITS    = 16,
  parameter int READ_WINDOW = 7,
  parameter int STUFF_RUN   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  logic       rdStb,
  output logic [7:0] rxData,
  output logic       ready,
  output logic       frameValid,
  output logic       frameErr,
  output logic       frameEnd
);
  symT        sym;
  dpCtlT      ctl;
  dpStatT     stat;
  logic [7:0] evictByte;

  hdlcRxLineSym #(.STUFF_RUN(STUFF_RUN)) uSym (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .sym(sym)
  );

  hdlcRxDatapath #(.FCS_BITS(FCS_BITS)) uDp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .ctl(ctl),
    .stat(stat), .evictByte(evictByte)
  );

  hdlcRxControl #(.READ_WINDOW(READ_WINDOW)) uCtl (
    .clk(clk), .rstN(rstN), .sym(sym), .stat(stat), .evictByte(evictByte),
    .rdStb(rdStb), .ctl(ctl), .rxData(rxData), .ready(ready),
    .frameValid(frameValid), .frameErr(frameErr), .frameEnd(frameEnd)
  );
endmodule

// File: rtl/hdlcRxDeframerChk.sv
`timescale 1ns/1ps
module hdlcRxDeframerChk #(
  parameter int READ_WINDOW = 7
) (
  input logic clk,
  input logic rstN,
  input logic rdStb,
  input logic ready,
  input logic frameValid,
  input logic frameErr,
  input logic frameEnd
);
  localparam int CW = $clog2(READ_WINDOW + 2);

  logic [CW-1:0] readyRun;

  always_ff @(posedge clk) begin
    if (!rstN || !ready) readyRun <= '0;
    else                 readyRun <= readyRun + 1'b1;
  end

  // R9
  ready_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> readyRun <= CW'(READ_WINDOW - 1));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && rdStb) |=> !ready);

  // R2
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> frameValid);

  // R9
  err_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> frameValid);

  // R10
  end_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> frameValid);

  // R10
  end_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (!frameValid && !frameErr && !frameEnd));
endmodule

bind hdlcRxDeframer hdlcRxDeframerChk #(.READ_WINDOW(READ_WINDOW)) uChk (
  .clk(clk), .rstN(rstN), .rdStb(rdStb), .ready(ready),
  .frameValid(frameValid), .frameErr(frameErr), .frameEnd(frameEnd)
);

// File: tb/hdlcRxDeframer_test.sv
`timescale 1ns/1ps
module hdlcRxDeframer_test;
  localparam int CYC = 20;
  localparam logic [1:0] M_GOOD = 2'd0, M_BADCRC = 2'd1, M_MISALIGN = 2'd2, M_ABORT = 2'd3;

  // {mode, length, payload bytes with byte 0 in bits 7:0}
  localparam logic [53:0] VEC [0:6] = '{
    {M_GOOD,     4'd3, 48'h0000_0003_0201},
    {M_GOOD,     4'd1, 48'h0000_0000_00A5},
    {M_GOOD,     4'd4, 48'h0000_1F3E_7EFF},
    {M_BADCRC,   4'd5, 48'h0050_4030_2010},
    {M_MISALIGN, 4'd2, 48'h0000_0000_3CC3},
    {M_ABORT,    4'd4, 48'h0000_4433_2211},
    {M_GOOD,     4'd6, 48'h5500_BE7F_FCF8}
  };

  logic clk = 1'b0, rstN = 1'b0, rxBit = 1'b1, rdStb = 1'b0;
  logic [7:0] rxData;
  logic ready, frameValid, frameErr, frameEnd;

  int checks = 0, errors = 0;
  int readDelay = 2, waitCnt = 0;
  int rcvCnt = 0, endCnt = 0, validCnt = 0, earlyErrCnt = 0;
  logic endErr = 1'b0;
  logic [7:0] rcv [0:255];
  int onesRun = 0;

  always #(CYC/2) clk = ~clk;

  hdlcRxDeframer uut (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rdStb(rdStb), .rxData(rxData),
    .ready(ready), .frameValid(frameValid), .frameErr(frameErr), .frameEnd(frameEnd)
  );

  // backend model and monitor, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      rdStb = 1'b0;
      waitCnt = 0;
    end else begin
      if (rdStb) rdStb = 1'b0;
      else if (ready) begin
        if (waitCnt == readDelay) begin
          rdStb = 1'b1;
          rcv[rcvCnt & 255] = rxData;
          rcvCnt++;
          waitCnt = 0;
        end else waitCnt++;
      end else waitCnt = 0;
      if (frameValid) validCnt++;
      if (frameValid && frameErr && !frameEnd) earlyErrCnt++;
      if (frameEnd) begin
        endCnt++;
        endErr = frameErr;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crcBench(input logic [15:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 16'h8408;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic sendRaw(input logic b);
    @(posedge clk);
    #2 rxBit = b;
  endtask

  task automatic sendData(input logic b);
    sendRaw(b);
    if (b) begin
      onesRun++;
      if (onesRun == 5) begin
        sendRaw(1'b0);
        onesRun = 0;
      end
    end else onesRun = 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendData(v[i]);
  endtask

  task automatic sendFlag();
    logic [7:0] f;
    f = 8'h7E;
    for (int i = 0; i < 8; i++) sendRaw(f[i]);
    onesRun = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendRaw(1'b1);
    onesRun = 0;
  endtask

  task automatic sendFrame(input logic [53:0] v);
    logic [1:0] mode;
    int len;
    logic [15:0] crc, fcs;
    mode = v[53:52];
    len = int'(v[51:48]);
    crc = 16'hFFFF;
    sendFlag();
    for (int i = 0; i < len; i++) begin
      sendByte(v[i*8 +: 8]);
      crc = crcBench(crc, v[i*8 +: 8]);
    end
    if (mode == M_ABORT) begin
      for (int i = 0; i < 8; i++) sendRaw(1'b1);
      idle(12);
    end else begin
      fcs = ~crc;
      if (mode == M_BADCRC) fcs[0] = ~fcs[0];
      sendByte(fcs[7:0]);
      sendByte(fcs[15:8]);
      if (mode == M_MISALIGN) sendData(1'b0);
      sendFlag();
      idle(12);
    end
  endtask

  initial begin
    #(CYC * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int eb, rb, vb, ee, len, mism;
    logic [1:0] mode;
    string req;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready in reset", int'(ready), 0);
    check("R1", "frameValid in reset", int'(frameValid), 0);
    check("R1", "frameErr in reset", int'(frameErr), 0);
    check("R1", "frameEnd in reset", int'(frameEnd), 0);
    @(posedge clk);
    #2 rstN = 1'b1;
    idle(10);

    // table of frames
    for (int k = 0; k < 7; k++) begin
      eb = endCnt; rb = rcvCnt;
      sendFrame(VEC[k]);
      mode = VEC[k][53:52];
      len = int'(VEC[k][51:48]);
      req = (mode == M_GOOD) ? "R4" : (mode == M_BADCRC) ? "R5" :
            (mode == M_MISALIGN) ? "R6" : "R7";
      check(req, $sformatf("frame %0d end pulses", k), endCnt - eb, 1);
      check(req, $sformatf("frame %0d frameErr at end", k), int'(endErr), (mode == M_GOOD) ? 0 : 1);
      check("R10", $sformatf("frame %0d frameValid after end", k), int'(frameValid), 0);
      if (mode != M_ABORT) begin
        check("R2", $sformatf("frame %0d bytes delivered", k), rcvCnt - rb, len);
        mism = 0;
        for (int i = 0; i < len; i++)
          if (rcv[(rb + i) & 255] != VEC[k][i*8 +: 8]) mism++;
        check((k == 2 || k == 6) ? "R3" : "R2", $sformatf("frame %0d payload mismatches", k), mism, 0);
      end
    end

    // R8: back-to-back flags
    vb = validCnt; eb = endCnt;
    sendFlag(); sendFlag(); sendFlag(); idle(12);
    check("R8", "valid cycles on bare flags", validCnt - vb, 0);
    check("R8", "end pulses on bare flags", endCnt - eb, 0);

    // R8: frame no longer than the FCS
    vb = validCnt; eb = endCnt;
    sendFlag(); sendByte(8'h12); sendByte(8'h34); sendFlag(); idle(12);
    check("R8", "valid cycles on short frame", validCnt - vb, 0);
    check("R8", "end pulses on short frame", endCnt - eb, 0);

    // R7: abort before any byte is delivered
    vb = validCnt; eb = endCnt;
    sendFlag(); sendByte(8'h5A);
    for (int i = 0; i < 8; i++) sendRaw(1'b1);
    idle(8);
    check("R7", "end pulses on early abort", endCnt - eb, 0);
    check("R7", "valid cycles on early abort", validCnt - vb, 0);

    // R9: read on the last legal edge
    readDelay = 6;
    eb = endCnt; rb = rcvCnt; ee = earlyErrCnt;
    sendFrame({M_GOOD, 4'd3, 48'h0000_0077_6655});
    check("R9", "late read end pulses", endCnt - eb, 1);
    check("R9", "late read frameErr", int'(endErr), 0);
    check("R9", "late read bytes", rcvCnt - rb, 3);
    check("R9", "late read early errors", earlyErrCnt - ee, 0);

    // R9: missed read window
    readDelay = 7;
    eb = endCnt; rb = rcvCnt; ee = earlyErrCnt;
    sendFrame({M_GOOD, 4'd3, 48'h0000_0099_8877});
    check("R9", "missed read bytes taken", rcvCnt - rb, 0);
    check("R9", "missed read error before end", int'(earlyErrCnt - ee > 0), 1);
    check("R9", "missed read frameErr at end", int'(endErr), 1);
    check("R10", "frameErr after end", int'(frameErr), 0);

    readDelay = 0;
    eb = endCnt;
    sendFrame({M_GOOD, 4'd2, 48'h0000_0000_0180});
    check("R4", "recovery frame frameErr", int'(endErr), 0);
    check("R4", "recovery frame end pulses", endCnt - eb, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule